// File: doc/BRIEF.md
# Supply-Tracking Limiter Threshold Calculator

This block turns a measured supply voltage into the threshold that an audio limiter should use. While the supply is healthy the threshold sits at a programmed ceiling. Once the supply falls below a programmed knee voltage, the threshold comes down with it at a programmed gain, so a weak battery lowers the level at which the limiter starts to act. A programmed floor stops the threshold from falling any further. If the knee is placed below any supply the system can reach, the threshold stays constant.

Every quantity is unsigned fixed point with 5 integer bits and 27 fractional bits. In that format 1.0 V, or a gain of 1.0 V/V, is `0x0800_0000`. The result is loaded into a register on a one-cycle sample strobe. It is marked valid in the cycle that follows the strobe and holds its value until the next strobe.

Top module: `supply_thr_calc`

## Requirements
- R1: While `rstN` is low, and after it is released before any strobe, `thrOut` is 0 and `thrValid` is 0.
- R2: If the supply at a strobe is greater than or equal to the knee and `thrFloor` ≤ `thrCeil`, the loaded threshold equals `thrCeil`.
- R3: If the supply at a strobe is below the knee, the drop is floor(`slope` × (`knee` − `supply`) / 2^27). The product is taken at full width and the fractional bits are truncated. The threshold is `thrCeil` − drop, with all values in 5.27 format (1.0 = `0x0800_0000`). A slope of 0 leaves the threshold at `thrCeil`.
- R4: If the drop is greater than or equal to `thrCeil`, the subtraction saturates at 0 and does not wrap.
- R5: The loaded threshold is never below `thrFloor`. After the subtraction, the larger of the subtraction result and `thrFloor` is taken.
- R6: `thrValid` is 1 in exactly the cycle after a cycle with `sampleStb` = 1, and 0 in every other cycle. `thrOut` takes its new value at that same edge.
- R7: In a cycle without a strobe, changes on `supply`, `thrCeil`, `thrFloor`, `knee` and `slope` do not change `thrOut`.
- R8: With `knee` = 0 the threshold equals `thrCeil` for any supply, and `thrFloor` has no effect as long as it does not exceed `thrCeil`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | Load a new threshold from the present inputs |
| supply | input | 32 | Measured supply voltage, 5.27 |
| thrCeil | input | 32 | Maximum threshold, 5.27 |
| thrFloor | input | 32 | Minimum threshold, 5.27 |
| knee | input | 32 | Supply voltage below which tracking starts, 5.27 |
| slope | input | 32 | Tracking gain in V/V, 5.27 |
| thrOut | output | 32 | Registered threshold, 5.27 |
| thrValid | output | 1 | One-cycle pulse marking a new `thrOut` |

## Verification
The block keeps only two pieces of state: the held threshold and the valid flag. Any fault in either shows up at the ports within one clock of the strobe that should have exposed it. A wrong slope product, a wrong shift position, or a subtraction that wraps instead of saturating gives a `thrOut` value that differs from the hand-computed one on the very next cycle. A valid flag stuck high, or a load enable that leaks when there is no strobe, shows up as a pulse that is too long or as a threshold that changes with no strobe.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int VAL_W  = 32;
  localparam int FRAC_W = 27;

  typedef struct packed {
    logic capture;
    logic publish;
  } thrCtl_t;
endpackage

// File: rtl/thr_ctrl.sv
module thr_ctrl
  import thr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleStb,
  output thrCtl_t ctl,
  output logic    validOut
);
  logic validQ;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= sampleStb;
  end

  always_comb begin
    ctl.capture = sampleStb;
    ctl.publish = validQ;
  end

  assign validOut = validQ;

  // R6: valid pulse follows a strobe by exactly one edge
  assert_valid_lag_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> validOut);
  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> !validOut);
endmodule

// File: rtl/thr_datapath.sv
module thr_datapath
  import thr_pkg::*;
#(
  parameter int W = VAL_W,
  parameter int F = FRAC_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  thrCtl_t      ctl,
  input  logic [W-1:0] supply,
  input  logic [W-1:0] thrCeil,
  input  logic [W-1:0] thrFloor,
  input  logic [W-1:0] knee,
  input  logic [W-1:0] slope,
  output logic [W-1:0] thrOut
);
  localparam int PW = 2 * W;
  localparam int DW = PW - F;

  logic         belowKnee;
  logic [W-1:0] deficit;
  logic [PW-1:0] prodFull;
  logic [DW-1:0] dropAmt;
  logic [DW-1:0] ceilExt;
  logic [W-1:0] tracked;
  logic [W-1:0] floored;
  logic [W-1:0] thrQ;

  always_comb begin
    belowKnee = supply < knee;
    deficit   = belowKnee ? (knee - supply) : '0;
    prodFull  = PW'(slope) * PW'(deficit);
    dropAmt   = DW'(prodFull >> F);
    ceilExt   = DW'(thrCeil);
    if (dropAmt >= ceilExt) tracked = '0;
    else                    tracked = thrCeil - W'(dropAmt);
    floored   = (tracked < thrFloor) ? thrFloor : tracked;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            thrQ <= '0;
    else if (ctl.capture) thrQ <= floored;
  end

  assign thrOut = thrQ;

  // R5: never below the floor that was present at the strobe
  assert_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> thrOut >= $past(thrFloor));
  // R2: at or above the knee the ceiling is passed through
  assert_flat_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && supply >= knee && thrFloor <= thrCeil) |=> thrOut == $past(thrCeil));
  // R3/R4: tracking never raises the threshold above the ceiling
  assert_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && thrFloor <= thrCeil) |=> thrOut <= $past(thrCeil));
  // R7: output holds between strobes
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(thrOut));
endmodule

// File: rtl/supply_thr_calc.sv
module supply_thr_calc
  import thr_pkg::*;
#(
  parameter int W = VAL_W,
  parameter int F = FRAC_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleStb,
  input  logic [W-1:0] supply,
  input  logic [W-1:0] thrCeil,
  input  logic [W-1:0] thrFloor,
  input  logic [W-1:0] knee,
  input  logic [W-1:0] slope,
  output logic [W-1:0] thrOut,
  output logic         thrValid
);
  thrCtl_t ctl;

  thr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleStb (sampleStb),
    .ctl       (ctl),
    .validOut  (thrValid)
  );

  thr_datapath #(.W(W), .F(F)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .supply   (supply),
    .thrCeil  (thrCeil),
    .thrFloor (thrFloor),
    .knee     (knee),
    .slope    (slope),
    .thrOut   (thrOut)
  );
endmodule

// File: tb/sim_supply_thr_calc.sv
module sim_supply_thr_calc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStb = 1'b0;
  logic [31:0] supply = '0, thrCeil = '0, thrFloor = '0, knee = '0, slope = '0;
  logic [31:0] thrOut;
  logic        thrValid;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  supply_thr_calc u0 (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .supply(supply),
    .thrCeil(thrCeil), .thrFloor(thrFloor), .knee(knee), .slope(slope),
    .thrOut(thrOut), .thrValid(thrValid)
  );

  // {supply, ceil, floor, knee, slope, expected}; 1.0 = 0x0800_0000
  localparam int NV = 12;
  localparam logic [191:0] VEC [NV] = '{
    {32'h3800_0000, 32'h4800_0000, 32'h2000_0000, 32'h3000_0000, 32'h0800_0000, 32'h4800_0000}, // R2 above knee
    {32'h3000_0000, 32'h4800_0000, 32'h2000_0000, 32'h3000_0000, 32'h0800_0000, 32'h4800_0000}, // R2 at knee
    {32'h2800_0000, 32'h4800_0000, 32'h2000_0000, 32'h3000_0000, 32'h0800_0000, 32'h4000_0000}, // R3 1V drop
    {32'h2000_0000, 32'h4800_0000, 32'h2000_0000, 32'h3000_0000, 32'h1000_0000, 32'h2800_0000}, // R3 slope 2
    {32'h1800_0000, 32'h4800_0000, 32'h2000_0000, 32'h3000_0000, 32'h1000_0000, 32'h2000_0000}, // R5 floor
    {32'h2C00_0000, 32'h4800_0000, 32'h2000_0000, 32'h3000_0000, 32'h0400_0000, 32'h4600_0000}, // R3 slope 0.5
    {32'h0000_0000, 32'h4800_0000, 32'h0000_0000, 32'h7800_0000, 32'h2000_0000, 32'h0000_0000}, // R4 saturate
    {32'h0000_0000, 32'h4800_0000, 32'h1000_0000, 32'h7800_0000, 32'h2000_0000, 32'h1000_0000}, // R4+R5
    {32'h0000_0000, 32'h4800_0000, 32'h0000_0000, 32'h4800_0000, 32'h0800_0000, 32'h0000_0000}, // R4 drop == ceil
    {32'h2FFF_FFFF, 32'h4800_0000, 32'h2000_0000, 32'h3000_0000, 32'h0800_0000, 32'h47FF_FFFF}, // R3 one lsb
    {32'h2FFF_FFFF, 32'h4800_0000, 32'h2000_0000, 32'h3000_0000, 32'h0400_0000, 32'h4800_0000}, // R3 truncation
    {32'h1000_0000, 32'h4800_0000, 32'h2000_0000, 32'h3000_0000, 32'h0000_0000, 32'h4800_0000}  // R3 slope 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobeLoad(input logic [31:0] s, c, f, k, m);
    @(negedge clk);
    supply = s; thrCeil = c; thrFloor = f; knee = k; slope = m;
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 thrOut in reset", thrOut, 32'h0);
    check("R1 thrValid in reset", {31'h0, thrValid}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 thrOut after release", thrOut, 32'h0);
    check("R1 thrValid after release", {31'h0, thrValid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      strobeLoad(VEC[i][191:160], VEC[i][159:128], VEC[i][127:96], VEC[i][95:64], VEC[i][63:32]);
      check($sformatf("R3 vector %0d thrOut", i), thrOut, VEC[i][31:0]);
      check("R6 valid after strobe", {31'h0, thrValid}, 32'h1);
    end

    @(negedge clk);
    check("R6 valid drops", {31'h0, thrValid}, 32'h0);

    // R7: inputs change without a strobe
    supply = 32'h0; knee = 32'h7800_0000; slope = 32'h2000_0000; thrCeil = 32'h1000_0000;
    repeat (3) @(negedge clk);
    check("R7 hold without strobe", thrOut, 32'h4800_0000);
    check("R6 no valid without strobe", {31'h0, thrValid}, 32'h0);

    // R8: knee at zero gives constant ceiling
    strobeLoad(32'h0000_0000, 32'h3C00_0000, 32'h2000_0000, 32'h0, 32'h1000_0000);
    check("R8 knee zero, supply 0", thrOut, 32'h3C00_0000);
    strobeLoad(32'h0800_0000, 32'h3C00_0000, 32'h3000_0000, 32'h0, 32'h1000_0000);
    check("R8 knee zero, supply 1V", thrOut, 32'h3C00_0000);

    // R6: back-to-back strobes keep valid high, each loads
    @(negedge clk);
    supply = 32'h2800_0000; thrCeil = 32'h4800_0000; thrFloor = 32'h0; knee = 32'h3000_0000; slope = 32'h0800_0000;
    sampleStb = 1'b1;
    @(negedge clk);
    check("R6 first of pair", thrOut, 32'h4000_0000);
    supply = 32'h2000_0000;
    @(negedge clk);
    sampleStb = 1'b0;
    check("R6 second of pair", thrOut, 32'h3800_0000);
    check("R6 valid second of pair", {31'h0, thrValid}, 32'h1);

    // R1: reset in mid-run clears state
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears thrOut", thrOut, 32'h0);
    check("R1 reset clears thrValid", {31'h0, thrValid}, 32'h0);
    rstN = 1'b1;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule